// File: doc/BRIEF.md
# Bus Cycle Timeout Watchdog

This block watches the address strobe of a shared bus and catches any cycle that stays open too long. The strobe can come from an internal or an external master. A cycle normally ends when the strobe falls. If the strobe is still high when a programmed limit runs out, the block raises a bus error. It holds that error until the strobe drops, and it also sets a sticky timeout flag that software clears by writing one. How the cycle gets acknowledged is handled elsewhere; this block only sees the strobe.

Time is counted in coarse units. A free-running 4-bit prescaler produces one tick every 16 clocks. A 10-bit down-counter counts those ticks. The counter is loaded from a 3-bit length code at the moment the strobe rises. Because the prescaler is not aligned to the start of the cycle, a real timeout can be up to 15 clocks shorter than the nominal length. An enable bit and the 3-bit code sit in a small configuration register. Software loads that register through a write strobe, and reset gives it known defaults.

Top module: `bus_cycle_watchdog`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `bus_err_o` and `timeout_flag_o` are both 0.
- R2: The length code `s` (0 to 7) gives a nominal limit T = 128·2^s clocks, so 0 means 128 and 7 means 16384. Count edges after the clock edge that first samples the strobe high, with the block enabled. `bus_err_o` first goes to 1 no earlier than edge T-15 and no later than edge T.
- R3: After a timeout, `bus_err_o` stays 1 for as long as the strobe stays high. It returns to 0 on the first clock edge that samples the strobe low.
- R4: `timeout_flag_o` goes to 1 on the same edge as the timeout. It stays 1 after the strobe falls.
- R5: A one-cycle pulse on `flag_clr_i` clears `timeout_flag_o` on the next edge. If a new timeout happens on that same edge, the timeout wins.
- R6: If the strobe falls before the limit, no bus error is raised and the flag stays unchanged. The next strobe assertion starts a fresh, full-length count.
- R7: While the enable bit is 0, `bus_err_o` stays 0 and the timeout flag is not set, however long the strobe is held.
- R8: After reset, the configuration register holds enable = 1 and length code = 7, so a strobe held high with no write times out after about 16384 clocks.
- R9: `cfg_we_i` loads `cfg_en_i` and `cfg_sel_i` on the same edge. A new length code takes effect only when the strobe next rises; a count already running keeps the length it was loaded with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_i | input | 1 | Bus address strobe, high while a cycle is open |
| cfg_we_i | input | 1 | Write strobe for the configuration register |
| cfg_en_i | input | 1 | Enable value to write |
| cfg_sel_i | input | 3 | Length code to write |
| flag_clr_i | input | 1 | Write-one-to-clear pulse for the timeout flag |
| bus_err_o | output | 1 | Bus error, held until the strobe is negated |
| timeout_flag_o | output | 1 | Sticky timeout status |

## Verification
Each output is registered once, so its effect appears on the edge after the stimulus is sampled:
- A strobe drop clears the error one edge later.
- A clear pulse clears the flag one edge later.
- A configuration write is visible on the edge that samples it.

The bench drives inputs on the falling clock edge and reads outputs on the next falling edge, which is exactly one rising edge later.

The timeout itself depends on the prescaler phase, which the bench does not model. Instead, the bench counts rising edges from the one that samples the strobe high. It then checks that the first error lands inside the 16-edge window R2 allows, and that none appeared before it.

// File: rtl/wd_pkg.sv
// Package: shared constants and the counter state type for the bus
// cycle watchdog. Assumes the prescaler width divides the base timeout.
package wd_pkg;
    localparam int WD_PRESC_W   = 4;   // prescaler bits, 16-clock tick
    localparam int WD_CNT_W     = 10;  // down-counter bits
    localparam int WD_SEL_W     = 3;   // length code bits
    localparam int WD_BASE_LOG2 = 7;   // shortest nominal limit = 2^7 clocks

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_COUNT = 2'd1,
        WD_FIRED = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wd_prescaler.sv
// Module: free-running prescaler producing one tick every 2^PRESC_W clocks.
// Assumes: runs from reset regardless of bus activity (phase is arbitrary
// relative to strobe assertion).
module wd_prescaler #(
    parameter int PRESC_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    logic [PRESC_W-1:0] presc_q;

    // Free-running count, wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_q + 1'b1;
    end

    assign tick_o = &presc_q;

    // R2: ticks never occur on consecutive cycles
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/wd_cfg.sv
// Module: configuration register holding enable and length code.
// Assumes: a single write strobe loads both fields together.
module wd_cfg #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             en_o,
    output logic [SEL_W-1:0] sel_o
);
    // Hold fields; reset to enabled, longest limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o  <= 1'b1;
            sel_o <= '1;
        end else if (we_i) begin
            en_o  <= en_i;
            sel_o <= sel_i;
        end
    end

    // R8: the first cycle after reset shows the default fields
    cfg_default_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (en_o && (&sel_o)));
endmodule

// File: rtl/wd_downcount.sv
// Module: per-cycle tick down-counter. Loads on the first run cycle,
// decrements on prescaler ticks, pulses expire once when a tick arrives
// at zero. Assumes run_i = strobe AND enable; dropping run_i aborts.
module wd_downcount #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             expire_o
);
    import wd_pkg::*;

    wd_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;

    assign expire_o = run_i && (state_q == WD_COUNT) && tick_i && (cnt_q == '0);

    // Sequence idle -> count -> fired, back to idle when run drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
        end else if (!run_i) begin
            state_q <= WD_IDLE;
        end else begin
            case (state_q)
                WD_IDLE: begin
                    state_q <= WD_COUNT;
                    cnt_q   <= load_i;
                end
                WD_COUNT: begin
                    if (tick_i) begin
                        if (cnt_q == '0) state_q <= WD_FIRED;
                        else             cnt_q   <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= state_q;
            endcase
        end
    end

    // R2: the count moves only on a tick
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && state_q == WD_COUNT && !tick_i) |=> $stable(cnt_q));

    // R6: losing run always returns to idle
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (state_q == WD_IDLE));
endmodule

// File: rtl/bus_cycle_watchdog.sv
// Module: bus cycle timeout watchdog top. Raises a held bus error and a
// sticky flag when the strobe stays high past the selected limit.
// Assumes: strobe_i is synchronous to clk, high while a cycle is open.
module bus_cycle_watchdog #(
    parameter int PRESC_W   = wd_pkg::WD_PRESC_W,
    parameter int CNT_W     = wd_pkg::WD_CNT_W,
    parameter int SEL_W     = wd_pkg::WD_SEL_W,
    parameter int BASE_LOG2 = wd_pkg::WD_BASE_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic             cfg_we_i,
    input  logic             cfg_en_i,
    input  logic [SEL_W-1:0] cfg_sel_i,
    input  logic             flag_clr_i,
    output logic             bus_err_o,
    output logic             timeout_flag_o
);
    localparam int SHIFT0 = BASE_LOG2 - PRESC_W;

    logic             tick;
    logic             en_q;
    logic [SEL_W-1:0] sel_q;
    logic             run;
    logic             expire;
    logic [CNT_W:0]   ticks_full;
    logic [CNT_W-1:0] load_val;

    wd_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    wd_cfg #(.SEL_W(SEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .en_i(cfg_en_i),
        .sel_i(cfg_sel_i), .en_o(en_q), .sel_o(sel_q)
    );

    // Tick count for the selected limit, minus one for the zero-tick expiry.
    always_comb begin
        ticks_full = (CNT_W+1)'(1) << (SHIFT0 + int'(sel_q));
        load_val   = CNT_W'(ticks_full - 1'b1);
    end

    assign run = strobe_i && en_q;

    wd_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick),
        .load_i(load_val), .expire_o(expire)
    );

    // Bus error: set on expiry, held while the strobe stays, dropped otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) bus_err_o <= 1'b0;
        else if (expire)    bus_err_o <= 1'b1;
    end

    // Sticky flag: expiry sets it with priority over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          timeout_flag_o <= 1'b0;
        else if (expire)     timeout_flag_o <= 1'b1;
        else if (flag_clr_i) timeout_flag_o <= 1'b0;
    end

    // R3
    err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> !bus_err_o);

    // R4
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_err_o) |-> timeout_flag_o);

    // R5
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !expire) |=> !timeout_flag_o);

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !bus_err_o);
endmodule

// File: tb/bus_cycle_watchdog_bench.sv
module bus_cycle_watchdog_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic       cfg_en_i = 1'b0;
    logic [2:0] cfg_sel_i = 3'd0;
    logic       flag_clr_i = 1'b0;
    logic       bus_err_o;
    logic       timeout_flag_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // {length code, nominal clocks}
    localparam int VEC [8][2] = '{
        '{0, 128}, '{1, 256}, '{2, 512}, '{3, 1024},
        '{4, 2048}, '{5, 4096}, '{6, 8192}, '{7, 16384}
    };

    always #2.5 clk = ~clk;

    bus_cycle_watchdog u_bus_cycle_watchdog (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .cfg_we_i(cfg_we_i),
        .cfg_en_i(cfg_en_i), .cfg_sel_i(cfg_sel_i), .flag_clr_i(flag_clr_i),
        .bus_err_o(bus_err_o), .timeout_flag_o(timeout_flag_o)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
            finish_run();
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(bit en, logic [2:0] sel);
        cfg_we_i = 1'b1; cfg_en_i = en; cfg_sel_i = sel;
        step();
        cfg_we_i = 1'b0;
    endtask

    // Raise strobe, count edges until error; check the R2 window.
    task automatic measure(string req, int nominal);
        int m = 0;
        int early = 0;
        strobe_i = 1'b1;
        while (m < nominal + 40) begin
            step();
            m++;
            if (bus_err_o) break;
        end
        // m-1 edges after the sampling edge
        if (bus_err_o && (m - 1) >= nominal - 15 && (m - 1) <= nominal) early = 1;
        checks++;
        if (!early) begin
            errors++;
            $display("FAIL %s: actual edge %0d err %0d expected edge in [%0d,%0d]",
                     req, m - 1, bus_err_o, nominal - 15, nominal);
        end
        chk({req, " flag R4"}, timeout_flag_o, 1);
    endtask

    task automatic end_cycle_and_clear();
        strobe_i = 1'b0;
        step();
        chk("R3 err drops", bus_err_o, 0);
        chk("R4 flag sticky", timeout_flag_o, 1);
        flag_clr_i = 1'b1;
        step();
        flag_clr_i = 1'b0;
        chk("R5 flag cleared", timeout_flag_o, 0);
    endtask

    initial begin
        @(negedge clk);
        repeat (4) step();
        chk("R1 err in reset", bus_err_o, 0);
        chk("R1 flag in reset", timeout_flag_o, 0);
        rst_n = 1'b1;
        step();
        chk("R1 err after reset", bus_err_o, 0);
        chk("R1 flag after reset", timeout_flag_o, 0);

        // R8: defaults give the longest limit with no write
        measure("R8 default limit", 16384);
        end_cycle_and_clear();

        // R2: table of length codes
        for (int i = 0; i < 8; i++) begin
            write_cfg(1'b1, 3'(VEC[i][0]));
            measure("R2 table", VEC[i][1]);
            end_cycle_and_clear();
        end

        // R3: error held while strobe stays high
        write_cfg(1'b1, 3'd0);
        measure("R3 setup", 128);
        repeat (60) step();
        chk("R3 err held", bus_err_o, 1);
        end_cycle_and_clear();

        // R6: abort before limit, no error; then a fresh full count
        strobe_i = 1'b1;
        repeat (100) step();
        strobe_i = 1'b0;
        step();
        chk("R6 no err on abort", bus_err_o, 0);
        chk("R6 no flag on abort", timeout_flag_o, 0);
        measure("R6 fresh count", 128);
        end_cycle_and_clear();

        // R7: disabled, long strobe gives nothing
        write_cfg(1'b0, 3'd0);
        strobe_i = 1'b1;
        repeat (400) step();
        chk("R7 err disabled", bus_err_o, 0);
        chk("R7 flag disabled", timeout_flag_o, 0);
        strobe_i = 1'b0;
        step();

        // R9: select change mid-cycle keeps the loaded length
        write_cfg(1'b1, 3'd3);
        strobe_i = 1'b1;
        repeat (10) step();
        write_cfg(1'b1, 3'd0);
        repeat (200) step();
        chk("R9 no early err", bus_err_o, 0);
        strobe_i = 1'b0;
        step();
        measure("R9 new length", 128);
        end_cycle_and_clear();

        finish_run();
    end
endmodule